// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timer

This block times one access on an 8080-style parallel display bus. A single-cycle start request, together with a read/write select and a command/data select, launches an access. The block then drives chip select, write enable, read enable and the command/data line, and enables the data-output drivers for writes. For reads, it samples the input data bus at a programmed point. When the access ends, it holds chip select inactive for a programmed gap and then pulses done. Every strobe edge is set in ticks through two 32-bit timing words. A granularity input sets a tick to one or two clock cycles. Each of the four bus lines has its own polarity input.

The timing words are taken when an access is accepted. Any edge that breaks an ordering rule is raised to its smallest legal value, and the access is flagged. A state machine runs the access through three states. IDLE waits for start. ACTIVE runs the tick counter through the cycle length. GAP holds chip select off for the pulse-width ticks. The transitions are IDLE to ACTIVE on an accepted start, ACTIVE to GAP at the end of the cycle when the gap is non-zero, ACTIVE to IDLE at the end of the cycle when the gap is zero, and GAP to IDLE when the gap ends. Both transitions into IDLE pulse done.

Top module: `pbus_strobe_timer`

## Requirements
- R1: After reset, the state is IDLE. `bus_oe_o`, `done_o`, `clamp_warn_o` and `rdata_o` are 0. Every bus line is at its inactive level, and the command/data line is deasserted.
- R2: The edge word packs the following fields: CS on in bits 3:0, CS off in bits 9:4, WE on in bits 13:10, WE off in bits 19:14, RE on in bits 23:20 and RE off in bits 29:24.
- R3: The cycle word packs the following fields: write cycle length in bits 5:0, read cycle length in bits 11:6, CS gap in bits 17:12 and read access time in bits 27:22. ACTIVE lasts exactly the effective cycle length in ticks. A write uses the write length and a read uses the read length.
- R4: With `tick_x2_i` = 0, a tick is one clock. With `tick_x2_i` = 1, a tick is two clocks. The value is taken at the start of each access.
- R5: The tick counter starts at 0 with the clock after acceptance. A strobe is asserted during ticks k with on <= k < off. WE is used only on writes, RE only on reads, and CS on both.
- R6: The following limits are enforced at acceptance: WE off >= WE on+1, RE off >= RE on+1, CS off >= max(CS on+1, WE off, RE off), access time >= RE on+1, write length >= CS off, and read length >= max(CS off, access time+1). `clamp_warn_o` shows, for the last accepted access, whether any of these values was raised.
- R7: On a read, the value on `bus_din_i` at the clock edge that ends tick number access time is stored. It appears on `rdata_o` and is held until the next such capture.
- R8: After ACTIVE, CS stays inactive for the gap in ticks. `done_o` is high for one clock, starting at the edge (cycle length + gap) ticks after acceptance.
- R9: `pol_i` bit 0 sets the polarity of A0, bit 1 RE, bit 2 WE and bit 3 CS. A clear bit makes the line low when asserted. A set bit makes it high when asserted.
- R10: A0 is asserted when `data_sel_i` was 1 at acceptance and keeps that level until the next access. On a write, `bus_oe_o` is high throughout ACTIVE and `bus_dout_o` carries the accepted write data.
- R11: A start request during ACTIVE or GAP is ignored. The running access keeps its data, timing and done point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access request, taken in IDLE |
| rd_i | input | 1 | 1 = read access, 0 = write access |
| data_sel_i | input | 1 | 1 = data access (A0 asserted), 0 = command |
| tick_x2_i | input | 1 | Tick granularity: 0 = one clock, 1 = two clocks |
| pol_i | input | 4 | Line polarity: bit0 A0, bit1 RE, bit2 WE, bit3 CS |
| edge_word_i | input | 32 | Strobe on/off edges in ticks |
| cycle_word_i | input | 32 | Cycle lengths, CS gap and access time in ticks |
| wdata_i | input | DATA_W | Write data |
| bus_din_i | input | DATA_W | Data bus input for reads |
| cs_o | output | 1 | Chip select pin |
| we_o | output | 1 | Write enable pin |
| re_o | output | 1 | Read enable pin |
| a0_o | output | 1 | Command/data pin |
| bus_dout_o | output | DATA_W | Data bus output |
| bus_oe_o | output | 1 | Data bus output enable |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-cycle pulse when the access and its gap end |
| clamp_warn_o | output | 1 | Last accepted access had a raised timing value |

## Verification
The timing words are generated arithmetically from a configuration index. This gives sets with zero edges, sets where off equals on, and sets where the cycle is shorter than the strobes, along with one set at the field maxima. Each set is run as a read and as a write, at both tick granularities, and under rotating polarity patterns. Every clock of every access is compared with a per-tick model of the strobe windows. This separates a wrong field slice, an off-by-one at a strobe edge, a missing or wrong clamp, and a tick that advances at the wrong rate. On some accesses, a second start arrives with changed data, direction and timing. This shows whether the running access latched its inputs or follows them live.

// File: rtl/pbus_strobe_pkg.sv
package pbus_strobe_pkg;

    localparam int CNT_W  = 7;
    localparam int LINE_N = 4;

    // line index inside the polarity vector
    localparam int LN_A0 = 0;
    localparam int LN_RE = 1;
    localparam int LN_WE = 2;
    localparam int LN_CS = 3;

    // edge word field positions
    localparam int CS_ON_LSB  = 0;
    localparam int CS_OFF_LSB = 4;
    localparam int WE_ON_LSB  = 10;
    localparam int WE_OFF_LSB = 14;
    localparam int RE_ON_LSB  = 20;
    localparam int RE_OFF_LSB = 24;
    localparam int ON_W       = 4;
    localparam int OFF_W      = 6;

    // cycle word field positions
    localparam int WR_LEN_LSB = 0;
    localparam int RD_LEN_LSB = 6;
    localparam int GAP_LSB    = 12;
    localparam int ACC_LSB    = 22;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } bus_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cs_on;
        logic [CNT_W-1:0] cs_off;
        logic [CNT_W-1:0] we_on;
        logic [CNT_W-1:0] we_off;
        logic [CNT_W-1:0] re_on;
        logic [CNT_W-1:0] re_off;
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] wr_len;
        logic [CNT_W-1:0] rd_len;
        logic [CNT_W-1:0] gap;
    } edge_set_t;

    function automatic logic [CNT_W-1:0] tmax(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbus_timing_clamp.sv
module pbus_timing_clamp
    import pbus_strobe_pkg::*;
(
    input  logic [31:0] edge_word_i,
    input  logic [31:0] cycle_word_i,
    output edge_set_t   eff_o,
    output logic        clamped_o
);

    edge_set_t raw;

    always_comb begin
        raw        = '0;
        raw.cs_on  = CNT_W'(edge_word_i[CS_ON_LSB  +: ON_W]);
        raw.cs_off = CNT_W'(edge_word_i[CS_OFF_LSB +: OFF_W]);
        raw.we_on  = CNT_W'(edge_word_i[WE_ON_LSB  +: ON_W]);
        raw.we_off = CNT_W'(edge_word_i[WE_OFF_LSB +: OFF_W]);
        raw.re_on  = CNT_W'(edge_word_i[RE_ON_LSB  +: ON_W]);
        raw.re_off = CNT_W'(edge_word_i[RE_OFF_LSB +: OFF_W]);
        raw.wr_len = CNT_W'(cycle_word_i[WR_LEN_LSB +: OFF_W]);
        raw.rd_len = CNT_W'(cycle_word_i[RD_LEN_LSB +: OFF_W]);
        raw.gap    = CNT_W'(cycle_word_i[GAP_LSB    +: OFF_W]);
        raw.acc    = CNT_W'(cycle_word_i[ACC_LSB    +: OFF_W]);
    end

    always_comb begin
        eff_o        = raw;
        eff_o.we_off = tmax(raw.we_off, raw.we_on + 1'b1);
        eff_o.re_off = tmax(raw.re_off, raw.re_on + 1'b1);
        eff_o.cs_off = tmax(tmax(raw.cs_off, raw.cs_on + 1'b1),
                            tmax(eff_o.we_off, eff_o.re_off));
        eff_o.acc    = tmax(raw.acc, raw.re_on + 1'b1);
        eff_o.wr_len = tmax(raw.wr_len, eff_o.cs_off);
        eff_o.rd_len = tmax(tmax(raw.rd_len, eff_o.cs_off), eff_o.acc + 1'b1);
        clamped_o    = (eff_o.we_off != raw.we_off) || (eff_o.re_off != raw.re_off)
                    || (eff_o.cs_off != raw.cs_off) || (eff_o.acc    != raw.acc)
                    || (eff_o.wr_len != raw.wr_len) || (eff_o.rd_len != raw.rd_len);
    end

endmodule

// File: rtl/pbus_tick_gen.sv
module pbus_tick_gen #(
    parameter int MAX_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic slow_i,
    output logic adv_o
);

    localparam int PH_W = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(MAX_DIV - 1);

    logic [PH_W-1:0] phase_q;

    assign adv_o = !slow_i || (phase_q == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart_i || adv_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/pbus_strobe_timer.sv
module pbus_strobe_timer
    import pbus_strobe_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic              data_sel_i,
    input  logic              tick_x2_i,
    input  logic [3:0]        pol_i,
    input  logic [31:0]       edge_word_i,
    input  logic [31:0]       cycle_word_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] bus_din_i,
    output logic              cs_o,
    output logic              we_o,
    output logic              re_o,
    output logic              a0_o,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              bus_oe_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              clamp_warn_o
);

    bus_state_t        state_q, state_d;
    edge_set_t         eff, tm_q;
    logic              clamped;
    logic [CNT_W-1:0]  cnt_q, len;
    logic              rd_q, a0_q, x2_q, warn_q, done_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              adv, accept, wrap, fin;
    logic              cs_l, we_l, re_l, active;
    logic [LINE_N-1:0] line_act, line_pin;

    pbus_timing_clamp u_clamp (
        .edge_word_i  (edge_word_i),
        .cycle_word_i (cycle_word_i),
        .eff_o        (eff),
        .clamped_o    (clamped)
    );

    pbus_tick_gen #(.MAX_DIV(2)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (accept),
        .slow_i    (x2_q),
        .adv_o     (adv)
    );

    assign accept = (state_q == ST_IDLE) && start_i;
    assign len    = rd_q ? tm_q.rd_len : tm_q.wr_len;

    // next state
    always_comb begin
        state_d = state_q;
        wrap    = 1'b0;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (adv && (cnt_q == len - 1'b1)) begin
                    wrap = 1'b1;
                    if (tm_q.gap == '0) begin
                        state_d = ST_IDLE;
                        fin     = 1'b1;
                    end else begin
                        state_d = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (adv && (cnt_q == tm_q.gap - 1'b1)) begin
                    wrap    = 1'b1;
                    state_d = ST_IDLE;
                    fin     = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tm_q    <= '0;
            rd_q    <= 1'b0;
            a0_q    <= 1'b0;
            x2_q    <= 1'b0;
            warn_q  <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= fin;
            if (accept) begin
                cnt_q   <= '0;
                tm_q    <= eff;
                rd_q    <= rd_i;
                a0_q    <= data_sel_i;
                x2_q    <= tick_x2_i;
                warn_q  <= clamped;
                wdata_q <= wdata_i;
            end else if ((state_q != ST_IDLE) && adv) begin
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end
            if ((state_q == ST_ACTIVE) && adv && rd_q && (cnt_q == tm_q.acc)) begin
                rdata_q <= bus_din_i;
            end
        end
    end

    // outputs
    always_comb begin
        active = (state_q == ST_ACTIVE);
        cs_l   = active && (cnt_q >= tm_q.cs_on) && (cnt_q < tm_q.cs_off);
        we_l   = active && !rd_q && (cnt_q >= tm_q.we_on) && (cnt_q < tm_q.we_off);
        re_l   = active &&  rd_q && (cnt_q >= tm_q.re_on) && (cnt_q < tm_q.re_off);
        line_act         = '0;
        line_act[LN_A0]  = a0_q;
        line_act[LN_RE]  = re_l;
        line_act[LN_WE]  = we_l;
        line_act[LN_CS]  = cs_l;
    end

    for (genvar g = 0; g < LINE_N; g++) begin : g_pol
        assign line_pin[g] = pol_i[g] ? line_act[g] : ~line_act[g];
    end

    assign a0_o         = line_pin[LN_A0];
    assign re_o         = line_pin[LN_RE];
    assign we_o         = line_pin[LN_WE];
    assign cs_o         = line_pin[LN_CS];
    assign bus_oe_o     = active && !rd_q;
    assign bus_dout_o   = wdata_q;
    assign rdata_o      = rdata_q;
    assign done_o       = done_q;
    assign clamp_warn_o = warn_q;

endmodule

// File: rtl/pbus_strobe_timer_chk.sv
module pbus_strobe_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] pol_i,
    input logic       cs_o,
    input logic       we_o,
    input logic       re_o,
    input logic       bus_oe_o,
    input logic       done_o
);

    logic cs_a, we_a, re_a;
    assign cs_a = pol_i[3] ? cs_o : ~cs_o;
    assign we_a = pol_i[2] ? we_o : ~we_o;
    assign re_a = pol_i[1] ? re_o : ~re_o;

    // R5
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(we_a && re_a));
    // R10
    we_drives_chk: assert property (@(posedge clk) disable iff (!rst_n) we_a |-> bus_oe_o);
    // R5
    re_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n) re_a |-> !bus_oe_o);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
    // R8
    done_cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !cs_a);

endmodule

bind pbus_strobe_timer pbus_strobe_timer_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pol_i    (pol_i),
    .cs_o     (cs_o),
    .we_o     (we_o),
    .re_o     (re_o),
    .bus_oe_o (bus_oe_o),
    .done_o   (done_o)
);

// File: tb/pbus_strobe_timer_tb_top.sv
module pbus_strobe_timer_tb_top;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, rd_i = 1'b0, data_sel_i = 1'b0, tick_x2_i = 1'b0;
    logic [3:0]    pol_i = 4'b0000;
    logic [31:0]   edge_word_i = '0, cycle_word_i = '0;
    logic [DW-1:0] wdata_i = '0, bus_din_i = '0;
    logic          cs_o, we_o, re_o, a0_o, bus_oe_o, done_o, clamp_warn_o;
    logic [DW-1:0] bus_dout_o, rdata_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pbus_strobe_timer #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .data_sel_i(data_sel_i), .tick_x2_i(tick_x2_i), .pol_i(pol_i),
        .edge_word_i(edge_word_i), .cycle_word_i(cycle_word_i),
        .wdata_i(wdata_i), .bus_din_i(bus_din_i),
        .cs_o(cs_o), .we_o(we_o), .re_o(re_o), .a0_o(a0_o),
        .bus_dout_o(bus_dout_o), .bus_oe_o(bus_oe_o), .rdata_o(rdata_o),
        .done_o(done_o), .clamp_warn_o(clamp_warn_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic pin(input logic asserted, input logic p);
        return p ? asserted : ~asserted;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [DW-1:0] din_at(input int n, input int i);
        return DW'(n * 37 + i * 5 + 1);
    endfunction

    task automatic run_access(input int i, input bit rd, input bit x2, input bit poke);
        int cson, csoff, weon, weoff, reon, reoff, acc, wcyc, rcyc, gap;
        int weoff_e, reoff_e, csoff_e, acc_e, wlen, rlen, len, tk, total;
        bit warn, dsel;
        logic [3:0] pol;
        logic [DW-1:0] wd;
        if (i == 16) begin
            cson = 15; csoff = 63; weon = 15; weoff = 63; reon = 15; reoff = 63;
            acc = 63; wcyc = 63; rcyc = 63; gap = 63;
        end else begin
            cson = i % 4; csoff = (i * 3) % 9; weon = i % 3; weoff = (i * 5) % 7;
            reon = i % 2; reoff = (i * 7) % 6; acc = (i * 3) % 5;
            wcyc = (i * 11) % 13; rcyc = (i * 5) % 11; gap = i % 4;
        end
        weoff_e = imax(weoff, weon + 1);
        reoff_e = imax(reoff, reon + 1);
        csoff_e = imax(imax(csoff, cson + 1), imax(weoff_e, reoff_e));
        acc_e   = imax(acc, reon + 1);
        wlen    = imax(wcyc, csoff_e);
        rlen    = imax(imax(rcyc, csoff_e), acc_e + 1);
        warn    = (weoff_e != weoff) || (reoff_e != reoff) || (csoff_e != csoff)
               || (acc_e != acc) || (wlen != wcyc) || (rlen != rcyc);
        len   = rd ? rlen : wlen;
        tk    = x2 ? 2 : 1;
        total = (len + gap) * tk;
        pol   = 4'((i * 5 + int'(rd) * 3 + int'(x2)) % 16);
        dsel  = i[0] ^ rd;
        wd    = DW'(16'hA500 + i * 3 + int'(x2));

        @(negedge clk);
        start_i   = 1'b1;
        rd_i      = rd;
        data_sel_i = dsel;
        tick_x2_i = x2;
        pol_i     = pol;
        wdata_i   = wd;
        // R2 R3: pack fields at their bit positions
        edge_word_i  = {2'b00, 6'(reoff), 4'(reon), 6'(weoff), 4'(weon), 6'(csoff), 4'(cson)};
        cycle_word_i = {4'b0000, 6'(acc), 4'b0000, 6'(gap), 6'(rcyc), 6'(wcyc)};
        @(posedge clk);
        for (int n = 0; n <= total; n++) begin
            @(negedge clk);
            bus_din_i = din_at(n, i);
            if (n == 0) begin
                if (poke) begin
                    // R11: second request while busy, with altered inputs
                    start_i = 1'b1;
                    rd_i = ~rd; data_sel_i = ~dsel; wdata_i = ~wd;
                    edge_word_i = '0; cycle_word_i = '0; tick_x2_i = ~x2;
                end else begin
                    start_i = 1'b0;
                end
            end else begin
                start_i = 1'b0;
            end
            begin
                bit act;
                int k;
                act = (n < len * tk);
                k   = n / tk;
                // R5 R4 R3 R9: strobe windows per tick
                chk("R5 cs", 32'(cs_o), 32'(pin(act && k >= cson && k < csoff_e, pol[3])));
                chk("R5 we", 32'(we_o), 32'(pin(act && !rd && k >= weon && k < weoff_e, pol[2])));
                chk("R5 re", 32'(re_o), 32'(pin(act && rd && k >= reon && k < reoff_e, pol[1])));
                // R10 output enable during active write
                chk("R10 oe", 32'(bus_oe_o), 32'(act && !rd));
                // R8 done point
                chk("R8 done", 32'(done_o), 32'(n == total));
                if (n == 0) begin
                    chk("R6 warn", 32'(clamp_warn_o), 32'(warn));
                    chk("R9 a0", 32'(a0_o), 32'(pin(dsel, pol[0])));
                end
                if (!rd && (n == 0 || n == 1))
                    chk("R10 dout", 32'(bus_dout_o), 32'(wd));
                if (n == 1 && poke)
                    chk("R11 a0 held", 32'(a0_o), 32'(pin(dsel, pol[0])));
                if (rd && n == total)
                    chk("R7 rdata", 32'(rdata_o), 32'(din_at((acc_e + 1) * tk - 1, i)));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state with pol 0 -> idle lines high
        chk("R1 cs", 32'(cs_o), 32'd1);
        chk("R1 we", 32'(we_o), 32'd1);
        chk("R1 re", 32'(re_o), 32'd1);
        chk("R1 a0", 32'(a0_o), 32'd1);
        chk("R1 oe", 32'(bus_oe_o), 32'd0);
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 warn", 32'(clamp_warn_o), 32'd0);
        chk("R1 rdata", 32'(rdata_o), 32'd0);
        rst_n = 1'b1;
        for (int x = 0; x < 2; x++)
            for (int r = 0; r < 2; r++)
                for (int i = 0; i <= 16; i++)
                    run_access(i, r[0], x[0], (i % 3) == 1);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule